// File: doc/BRIEF.md
# Single-Wire Bus Slave ROM Command Layer

This block is the addressing layer of a slave on a single-wire, open-drain bus. It works one bit slot at a time. A lower layer reports three kinds of event: a bus reset, a bit written by the master, and a read slot opened by the master. This block answers with the level to put on the line, where 0 means pull low and 1 means release. Because the line is wired-AND, several slaves can answer in the same slot.

The slave holds a 64-bit identity, which is a family byte, a 48-bit serial number and a check byte, with bit 0 first on the wire. After each bus reset it takes an 8-bit command. Four commands are recognised. Read sends the identity out. Match compares an address from the master with the identity. Search takes part in the master's bit-by-bit tree walk over all slaves. Skip selects the slave without any address. A successful match or skip raises `selected`, which hands the bus to the memory-function layer that follows. Presence generation, slot timing and CRC calculation belong to other blocks.

Top module: `ow_rom_layer`

## Requirements
- R1: After `rst_n` is released, and until the first `bus_rst`, the slave is inactive. `tx_bit` stays 1, `selected` stays 0, and written bits are ignored.
- R2: After `bus_rst` the slave takes the next 8 written bits as a command, least significant bit first. The command codes are 33h for read, 55h for match, F0h for search and CCh for skip.
- R3: Read (33h): on each of the next 64 read slots `tx_bit` shows identity bit 0, then bit 1, and so on up to bit 63. After that the bus stays released and `selected` stays 0.
- R4: Match (55h): the next 64 written bits are compared in order with identity bits 0 to 63. If all of them are equal, `selected` rises in the cycle after the 64th bit.
- R5: Match with any unequal bit: `selected` never rises, and `tx_bit` stays 1 until the next `bus_rst`.
- R6: Search (F0h): for each identity bit, starting from bit 0, the first read slot shows the bit, the second read slot shows its complement, and the following written bit is compared with it.
- R7: Search, when a written direction bit differs from the identity bit: the slave stops taking part, and every later read slot sees 1 until the next `bus_rst`.
- R8: Search that runs through all 64 triplets: the slave then releases the bus and does not assert `selected`.
- R9: Skip (CCh): `selected` rises in the cycle after the 8th command bit.
- R10: Any other command code leaves the slave released (`tx_bit` = 1, `selected` = 0). It ignores all further bits until the next `bus_rst`.
- R11: `bus_rst` in any state aborts the current operation and clears `selected` in the next cycle. The slave then expects a new command.
- R12: Whenever the slave is not sending an identity bit or its complement, `tx_bit` is 1. This also holds while `selected` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_code | input | ID_W | Identity of the slave, bit 0 is sent first |
| bus_rst | input | 1 | One-cycle pulse: a bus reset was detected |
| rd_slot | input | 1 | One-cycle pulse: the master opened a read slot, and `tx_bit` is consumed |
| wr_valid | input | 1 | One-cycle pulse: the master wrote a bit |
| wr_bit | input | 1 | Value of the written bit |
| tx_bit | output | 1 | Level to drive: 0 pulls the line low, 1 releases it |
| selected | output | 1 | The slave is addressed and the memory layer may proceed |

## Verification
The assertions check on every cycle that a selected, parked or inactive slave keeps the line released. They also check that a bus reset always drops `selected`, that `selected` only rises on a received bit and then holds until a reset, and that the second slot of a search triplet shows the complement of the first. Only the bench scenarios can show the wire order of the read and search bits and which exact identity values select. They also cover the bit-reversed command that decodes as read, and the recovery from a reset in the middle of an operation.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_CMD,
      ST_READ,
      ST_MATCH,
      ST_SEARCH,
      ST_SEL,
      ST_PARK
   } rom_state_t;

   typedef enum logic [1:0] {
      PH_TRUE,
      PH_COMP,
      PH_DIR
   } srch_phase_t;

   localparam logic [7:0] CODE_READ   = 8'h33;
   localparam logic [7:0] CODE_MATCH  = 8'h55;
   localparam logic [7:0] CODE_SEARCH = 8'hF0;
   localparam logic [7:0] CODE_SKIP   = 8'hCC;

endpackage

// File: rtl/ow_rom_shift.sv
module ow_rom_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] word_next,
   output logic         last
);
   localparam int CW = (W > 1) ? $clog2(W) : 1;

   logic [CW-1:0] cnt;

   generate
      if (W > 1) begin : g_wide
         logic [W-2:0] hold;
         assign word_next = {din, hold};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  hold <= '0;
            else if (en) hold <= word_next[W-1:1];
         end
      end else begin : g_single
         assign word_next = din;
      end
   endgenerate

   assign last = (cnt == CW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= last ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/ow_rom_index.sv
module ow_rom_index #(
   parameter int N = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 inc,
   output logic [$clog2(N)-1:0] idx,
   output logic                 at_last
);
   localparam int IW = $clog2(N);

   assign at_last = (idx == IW'(N - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx <= '0;
      else if (clr) idx <= '0;
      else if (inc) idx <= idx + 1'b1;
   end
endmodule

// File: rtl/ow_rom_bitsel.sv
module ow_rom_bitsel #(
   parameter int N         = 64,
   parameter bit SEL_ANDOR = 1'b0
) (
   input  logic [N-1:0]         vec,
   input  logic [$clog2(N)-1:0] idx,
   output logic                 bit_o
);
   localparam int IW = $clog2(N);

   generate
      if (SEL_ANDOR) begin : g_andor
         logic [N-1:0] hit;
         for (genvar i = 0; i < N; i++) begin : g_hit
            assign hit[i] = vec[i] & (idx == IW'(i));
         end
         assign bit_o = |hit;
      end else begin : g_index
         assign bit_o = vec[idx];
      end
   endgenerate
endmodule

// File: rtl/ow_rom_layer.sv
module ow_rom_layer
   import ow_rom_pkg::*;
#(
   parameter int         ID_W        = 64,
   parameter int         CMD_W       = 8,
   parameter bit         SEL_ANDOR   = 1'b0,
   parameter logic [7:0] CMD_READ    = CODE_READ,
   parameter logic [7:0] CMD_MATCH   = CODE_MATCH,
   parameter logic [7:0] CMD_SEARCH  = CODE_SEARCH,
   parameter logic [7:0] CMD_SKIP    = CODE_SKIP
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ID_W-1:0] id_code,
   input  logic            bus_rst,
   input  logic            rd_slot,
   input  logic            wr_valid,
   input  logic            wr_bit,
   output logic            tx_bit,
   output logic            selected
);
   localparam int IW = $clog2(ID_W);

   generate
      if (ID_W < 2 || (ID_W & (ID_W - 1)) != 0) begin : g_bad_id
         $error("ow_rom_layer: ID_W must be a power of two of at least 2");
      end
      if (CMD_W != 8) begin : g_bad_cmd
         $error("ow_rom_layer: CMD_W must be 8 for the command codes");
      end
      if (CMD_READ == CMD_MATCH || CMD_READ == CMD_SEARCH || CMD_READ == CMD_SKIP ||
          CMD_MATCH == CMD_SEARCH || CMD_MATCH == CMD_SKIP || CMD_SEARCH == CMD_SKIP) begin : g_bad_codes
         $error("ow_rom_layer: command codes must be distinct");
      end
   endgenerate

   rom_state_t  st, st_n;
   srch_phase_t ph, ph_n;

   logic [CMD_W-1:0] cmd_word;
   logic             cmd_last;
   logic             cmd_en;
   logic [IW-1:0]    idx;
   logic             idx_last;
   logic             idx_inc;
   logic             id_bit;

   assign cmd_en = (st == ST_CMD) && wr_valid && !bus_rst;

   ow_rom_shift #(.W(CMD_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .clr(bus_rst), .en(cmd_en), .din(wr_bit),
      .word_next(cmd_word), .last(cmd_last)
   );

   ow_rom_index #(.N(ID_W)) u_idx (
      .clk(clk), .rst_n(rst_n), .clr(bus_rst), .inc(idx_inc),
      .idx(idx), .at_last(idx_last)
   );

   ow_rom_bitsel #(.N(ID_W), .SEL_ANDOR(SEL_ANDOR)) u_sel (
      .vec(id_code), .idx(idx), .bit_o(id_bit)
   );

   always_comb begin
      st_n    = st;
      ph_n    = ph;
      idx_inc = 1'b0;
      case (st)
         ST_CMD: begin
            if (wr_valid && cmd_last) begin
               if (cmd_word == CMD_READ)        st_n = ST_READ;
               else if (cmd_word == CMD_MATCH)  st_n = ST_MATCH;
               else if (cmd_word == CMD_SEARCH) begin
                  st_n = ST_SEARCH;
                  ph_n = PH_TRUE;
               end
               else if (cmd_word == CMD_SKIP)   st_n = ST_SEL;
               else                             st_n = ST_PARK;
            end
         end
         ST_READ: begin
            if (rd_slot) begin
               if (idx_last) st_n = ST_PARK;
               else          idx_inc = 1'b1;
            end
         end
         ST_MATCH: begin
            if (wr_valid) begin
               if (wr_bit != id_bit) st_n = ST_PARK;
               else if (idx_last)    st_n = ST_SEL;
               else                  idx_inc = 1'b1;
            end
         end
         ST_SEARCH: begin
            case (ph)
               PH_TRUE: if (rd_slot) ph_n = PH_COMP;
               PH_COMP: if (rd_slot) ph_n = PH_DIR;
               default: begin
                  if (wr_valid) begin
                     if (wr_bit != id_bit || idx_last) st_n = ST_PARK;
                     else begin
                        idx_inc = 1'b1;
                        ph_n    = PH_TRUE;
                     end
                  end
               end
            endcase
         end
         default: ;
      endcase
      if (bus_rst) begin
         st_n    = ST_CMD;
         ph_n    = PH_TRUE;
         idx_inc = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_OFF;
         ph <= PH_TRUE;
      end else begin
         st <= st_n;
         ph <= ph_n;
      end
   end

   always_comb begin
      tx_bit = 1'b1;
      if (st == ST_READ) tx_bit = id_bit;
      else if (st == ST_SEARCH) begin
         if (ph == PH_TRUE)      tx_bit = id_bit;
         else if (ph == PH_COMP) tx_bit = ~id_bit;
      end
   end

   assign selected = (st == ST_SEL);
endmodule

// File: rtl/ow_rom_checker.sv
module ow_rom_checker
   import ow_rom_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        bus_rst,
   input logic        rd_slot,
   input logic        wr_valid,
   input logic        tx_bit,
   input logic        selected,
   input rom_state_t  st,
   input srch_phase_t ph
);
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OFF) |-> (tx_bit && !selected)); // R1

   AST_PARK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PARK) |-> (tx_bit && !selected)); // R10

   AST_SEL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      selected |-> tx_bit); // R12

   AST_RST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> !selected); // R11

   AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (selected && !bus_rst) |=> selected); // R9

   AST_SEL_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(selected) |-> ($past(wr_valid) && !$past(bus_rst))); // R4

   AST_SEARCH_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SEARCH && ph == PH_TRUE && rd_slot && !bus_rst) |=> (tx_bit != $past(tx_bit))); // R6
endmodule

bind ow_rom_layer ow_rom_checker u_ow_rom_checker (
   .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rd_slot(rd_slot),
   .wr_valid(wr_valid), .tx_bit(tx_bit), .selected(selected),
   .st(st), .ph(ph)
);

// File: tb/ow_rom_layer_tb.sv
module ow_rom_layer_tb_top;
   localparam int ID_W = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [ID_W-1:0] id_code = '0;
   logic            bus_rst = 1'b0;
   logic            rd_slot = 1'b0;
   logic            wr_valid = 1'b0;
   logic            wr_bit = 1'b0;
   logic            tx_bit;
   logic            selected;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   ow_rom_layer dut_i (
      .clk(clk), .rst_n(rst_n), .id_code(id_code), .bus_rst(bus_rst),
      .rd_slot(rd_slot), .wr_valid(wr_valid), .wr_bit(wr_bit),
      .tx_bit(tx_bit), .selected(selected)
   );

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
         report();
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit exp_true(input logic [ID_W-1:0] id, input int i);
      return id[i];
   endfunction

   function automatic bit exp_comp(input logic [ID_W-1:0] id, input int i);
      return ~id[i];
   endfunction

   function automatic bit is_known(input logic [7:0] c);
      return c == 8'h33 || c == 8'h55 || c == 8'hF0 || c == 8'hCC;
   endfunction

   task automatic do_bus_reset();
      @(negedge clk) bus_rst = 1'b1;
      @(negedge clk) bus_rst = 1'b0;
   endtask

   task automatic wbit(input bit b);
      @(negedge clk) begin wr_valid = 1'b1; wr_bit = b; end
      @(negedge clk) wr_valid = 1'b0;
   endtask

   task automatic rslot(output bit b);
      @(negedge clk) begin b = tx_bit; rd_slot = 1'b1; end
      @(negedge clk) rd_slot = 1'b0;
   endtask

   task automatic wbyte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) wbit(v[i]);
   endtask

   task automatic new_id();
      id_code = {$urandom(), $urandom()};
   endtask

   initial begin
      bit b, b2;
      logic [7:0] c;
      int k;
      void'($urandom(32'd1234));
      new_id();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_bit == 1'b1 && selected == 1'b0, "R1 reset state", {tx_bit, selected}, 2'b10);

      // R1: commands before the first bus reset are ignored
      wbyte(8'hCC);
      check(selected == 1'b0, "R1 skip before bus reset", selected, 0);
      rslot(b);
      check(b == 1'b1, "R1 released before bus reset", b, 1);

      // R9: skip
      do_bus_reset();
      wbyte(8'hCC);
      check(selected == 1'b1, "R9 skip selects", selected, 1);
      rslot(b);
      check(b == 1'b1, "R12 released while selected", b, 1);
      do_bus_reset();
      check(selected == 1'b0, "R11 reset clears selected", selected, 1'b0);

      // R3: read ROM with several identities
      for (int t = 0; t < 4; t++) begin
         new_id();
         do_bus_reset();
         wbyte(8'h33);
         for (int i = 0; i < ID_W; i++) begin
            rslot(b);
            check(b == exp_true(id_code, i), "R3 read bit", b, exp_true(id_code, i));
         end
         rslot(b);
         check(b == 1'b1 && selected == 1'b0, "R3 released after read", {b, selected}, 2'b10);
      end

      // R2: CCh sent most significant bit first is decoded as 33h (read)
      new_id();
      do_bus_reset();
      for (int i = 7; i >= 0; i--) wbit(c_cc(i));
      check(selected == 1'b0, "R2 bit order not skip", selected, 0);
      rslot(b);
      check(b == id_code[0], "R2 bit order decoded as read", b, id_code[0]);

      // R4 / R5: match
      for (int t = 0; t < 6; t++) begin
         new_id();
         do_bus_reset();
         wbyte(8'h55);
         k = (t % 2 == 0) ? -1 : ((t == 1) ? 63 : int'($urandom_range(0, 62)));
         for (int i = 0; i < ID_W; i++) begin
            wbit((i == k) ? ~id_code[i] : id_code[i]);
            if (i == ID_W - 2 && k < 0)
               check(selected == 1'b0, "R4 not selected before last bit", selected, 0);
         end
         if (k < 0) check(selected == 1'b1, "R4 match selects", selected, 1);
         else begin
            check(selected == 1'b0, "R5 mismatch not selected", selected, 0);
            rslot(b);
            check(b == 1'b1, "R5 released after mismatch", b, 1);
         end
      end

      // R6 / R8: complete search following the identity
      for (int t = 0; t < 3; t++) begin
         new_id();
         do_bus_reset();
         wbyte(8'hF0);
         for (int i = 0; i < ID_W; i++) begin
            rslot(b);
            rslot(b2);
            check(b == exp_true(id_code, i) && b2 == exp_comp(id_code, i),
                  "R6 search triplet", {b, b2}, {exp_true(id_code, i), exp_comp(id_code, i)});
            wbit(id_code[i]);
         end
         rslot(b);
         check(b == 1'b1 && selected == 1'b0, "R8 released after search", {b, selected}, 2'b10);
      end

      // R7: search with a wrong direction bit
      for (int t = 0; t < 3; t++) begin
         new_id();
         k = int'($urandom_range(0, 62));
         do_bus_reset();
         wbyte(8'hF0);
         for (int i = 0; i <= k; i++) begin
            rslot(b);
            rslot(b2);
            wbit((i == k) ? ~id_code[i] : id_code[i]);
         end
         rslot(b);
         rslot(b2);
         check(b == 1'b1 && b2 == 1'b1, "R7 dropped out of search", {b, b2}, 2'b11);
         check(selected == 1'b0, "R7 not selected", selected, 0);
      end

      // R10: unrecognised codes
      for (int t = 0; t < 4; t++) begin
         do c = 8'($urandom()); while (is_known(c));
         do_bus_reset();
         wbyte(c);
         rslot(b);
         check(b == 1'b1 && selected == 1'b0, "R10 unknown code released", {b, selected}, 2'b10);
         wbyte(8'hCC);
         check(selected == 1'b0, "R10 later bits ignored", selected, 0);
      end

      // R11: reset in the middle of match and read
      new_id();
      do_bus_reset();
      wbyte(8'h55);
      for (int i = 0; i < 20; i++) wbit(id_code[i]);
      do_bus_reset();
      wbyte(8'hCC);
      check(selected == 1'b1, "R11 reset aborts match", selected, 1);
      do_bus_reset();
      wbyte(8'h33);
      for (int i = 0; i < 10; i++) rslot(b);
      do_bus_reset();
      wbyte(8'h33);
      rslot(b);
      check(b == id_code[0], "R11 read restarts at bit 0", b, id_code[0]);

      done = 1'b1;
      report();
   end

   function automatic bit c_cc(input int i);
      logic [7:0] v = 8'hCC;
      return v[i];
   endfunction
endmodule